// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This controller erases or programs one bank of a byte-wide parallel flash through a simple synchronous bus. The bus has an address, a write-data byte, a read-data byte, a write strobe and a read strobe. A start pulse launches an operation. An operation-select input chooses erase or program, and a bank index picks the bank. Program mode takes the bank's contents from a local buffer that the block addresses through its own byte-offset port.

Each operation uses the status-register command set. First the block issues the erase or write command bytes. It then polls the status register until the ready bit appears or the attempt budget runs out. It clears status, returns the part to array-read mode, and reads every byte of the bank back. Timeout, verify failure and a small error code stay visible after the one-cycle done pulse until the next operation is accepted.

Bus timing model:

- Every strobe lasts exactly one cycle.
- Read data arrives on the cycle after the read strobe.
- The buffer answers in the same cycle its offset is presented.
- Between a write-setup byte and the data byte that follows it there is one settle cycle.

Top module: `flash_bank_prog`

## Requirements
- R1: After reset, busy, done, timeout, verify_fail, err_code, fl_we and fl_re are all 0.
- R2: An erase writes 0x20 and then 0xD0 to the first address of the selected bank, on consecutive cycles.
- R3: Program handles the bank's bytes in ascending offset order. For each byte it writes 0x40 to that byte's address, waits one cycle with no strobe, then writes the buffer byte (buf_addr equal to the offset) to the same address.
- R4: Each poll attempt writes 0x70 to the bank's first address and raises fl_re there on the next cycle. It samples fl_rdata one cycle later. The operation is complete when bit 7 of that byte is 1.
- R5: When POLL_LIMIT attempts pass without completion, timeout is set. The block then skips to the clear step, and any remaining program bytes are abandoned.
- R6: After polling ends, the block writes 0x50 and then 0xFF to the bank's first address, on consecutive cycles.
- R7: Verify reads every offset of the bank in ascending order. The expected byte is 0xFF after an erase and the buffer byte after a program. Any mismatch sets verify_fail.
- R8: At every completed poll, status bits 5:3 are ORed into err_code[2:0]. For program this accumulates over all bytes.
- R9: The block raises done for exactly one cycle, in the cycle busy returns to 0. The result flags hold until the next accepted start clears them.
- R10: A start that arrives while busy is ignored. It changes neither the bank, the operation, nor the bus sequence in progress.
- R11: Every flash address carries the latched bank index in its upper bits and a byte offset in its lower OFF_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| op_prog | input | 1 | 1 = program from buffer, 0 = erase |
| bank | input | BANK_W | Bank index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Polling gave up |
| verify_fail | output | 1 | Read-back mismatch seen |
| err_code | output | 3 | Accumulated status bits 5:3 |
| buf_addr | output | OFF_W | Offset into the local buffer |
| buf_rdata | input | 8 | Buffer byte at buf_addr |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read byte, valid the cycle after fl_re |

## Verification
The hardest situations to reach are two:

- A program timeout that strikes after some bytes are already written, so the rest of the bank is skipped and the verify pass must catch the gap.
- A verify mismatch on a single byte of an otherwise correct bank.

The bench's behavioural flash has three knobs: a status delay that can be made longer than the whole poll budget, an injected status error field, and one corrupting address that stores a wrong value on erase or program. A reference sequence built from the requirements predicts every bus cycle, including the extra polls, the early abort and the flag values.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_WRITE_SETUP = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_ARRAY       = 8'hFF;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;
  localparam int         READY_BIT       = 7;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ERS_SETUP,
    S_ERS_GO,
    S_PRG_SETUP,
    S_PRG_SETTLE,
    S_PRG_DATA,
    S_POLL_CMD,
    S_POLL_RD,
    S_POLL_CHK,
    S_CLEAR,
    S_ARRAY,
    S_VFY_RD,
    S_VFY_CHK
  } fbp_state_e;
endpackage

// File: rtl/fbp_index.sv
module fbp_index #(
  parameter  int COUNT = 8192,
  localparam int W     = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (clr | inc) idx <= idx_d;
  end

  assign last = (idx == W'(COUNT - 1));

  // R7
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);
endmodule

// File: rtl/fbp_poll_timer.sv
module fbp_poll_timer #(
  parameter  int LIMIT = 1000000,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr | inc) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(LIMIT));

  // R5
  poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !expired);
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter  int BANK_BYTES = 8192,
  parameter  int NUM_BANKS  = 2,
  parameter  int POLL_LIMIT = 1000000,
  localparam int OFF_W      = $clog2(BANK_BYTES),
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = OFF_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_prog,
  input  logic [BANK_W-1:0] bank,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              verify_fail,
  output logic [2:0]        err_code,
  output logic [OFF_W-1:0]  buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata
);
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  fbp_state_e       st_q, st_d;
  logic             op_q;
  logic [BANK_W-1:0] bank_q;
  logic             idx_clr, idx_inc, idx_last;
  logic [OFF_W-1:0] idx;
  logic             poll_clr, poll_inc, poll_expired;
  logic             off_sel;
  logic             accept, ready_seen, vfy_bad;
  logic [7:0]       vfy_exp;

  fbp_index #(.COUNT(BANK_BYTES)) u_index (
    .clk(clk), .rst_n(rst_s), .clr(idx_clr), .inc(idx_inc),
    .idx(idx), .last(idx_last));

  fbp_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_s), .clr(poll_clr), .inc(poll_inc),
    .expired(poll_expired));

  assign accept     = (st_q == S_IDLE) && start;
  assign ready_seen = fl_rdata[READY_BIT];
  assign vfy_exp    = op_q ? buf_rdata : ERASED_BYTE;
  assign vfy_bad    = (fl_rdata != vfy_exp);

  always_comb begin
    st_d     = st_q;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    off_sel  = 1'b0;
    fl_wdata = 8'h00;
    case (st_q)
      S_IDLE: if (start) begin
        idx_clr = 1'b1;
        st_d    = op_prog ? S_PRG_SETUP : S_ERS_SETUP;
      end
      S_ERS_SETUP: begin
        fl_we = 1'b1; fl_wdata = CMD_ERASE_SETUP; poll_clr = 1'b1;
        st_d  = S_ERS_GO;
      end
      S_ERS_GO: begin
        fl_we = 1'b1; fl_wdata = CMD_ERASE_GO;
        st_d  = S_POLL_CMD;
      end
      S_PRG_SETUP: begin
        fl_we = 1'b1; off_sel = 1'b1; fl_wdata = CMD_WRITE_SETUP;
        poll_clr = 1'b1;
        st_d  = S_PRG_SETTLE;
      end
      S_PRG_SETTLE: st_d = S_PRG_DATA;
      S_PRG_DATA: begin
        fl_we = 1'b1; off_sel = 1'b1; fl_wdata = buf_rdata;
        st_d  = S_POLL_CMD;
      end
      S_POLL_CMD: begin
        fl_we = 1'b1; fl_wdata = CMD_STATUS; poll_inc = 1'b1;
        st_d  = S_POLL_RD;
      end
      S_POLL_RD: begin
        fl_re = 1'b1;
        st_d  = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (ready_seen) begin
          if (op_q && !idx_last) begin
            idx_inc = 1'b1;
            st_d    = S_PRG_SETUP;
          end else begin
            st_d = S_CLEAR;
          end
        end else if (poll_expired) begin
          st_d = S_CLEAR;
        end else begin
          st_d = S_POLL_CMD;
        end
      end
      S_CLEAR: begin
        fl_we = 1'b1; fl_wdata = CMD_CLEAR;
        st_d  = S_ARRAY;
      end
      S_ARRAY: begin
        fl_we = 1'b1; fl_wdata = CMD_ARRAY; idx_clr = 1'b1;
        st_d  = S_VFY_RD;
      end
      S_VFY_RD: begin
        fl_re = 1'b1; off_sel = 1'b1;
        st_d  = S_VFY_CHK;
      end
      S_VFY_CHK: begin
        if (idx_last) st_d = S_IDLE;
        else begin
          idx_inc = 1'b1;
          st_d    = S_VFY_RD;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q        <= S_IDLE;
      op_q        <= 1'b0;
      bank_q      <= '0;
      timeout     <= 1'b0;
      verify_fail <= 1'b0;
      err_code    <= 3'b000;
      done        <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= (st_q == S_VFY_CHK) && idx_last;
      if (accept) begin
        op_q        <= op_prog;
        bank_q      <= bank;
        timeout     <= 1'b0;
        verify_fail <= 1'b0;
        err_code    <= 3'b000;
      end
      if ((st_q == S_POLL_CHK) && ready_seen)
        err_code <= err_code | fl_rdata[5:3];
      if ((st_q == S_POLL_CHK) && !ready_seen && poll_expired)
        timeout <= 1'b1;
      if ((st_q == S_VFY_CHK) && vfy_bad)
        verify_fail <= 1'b1;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign buf_addr = idx;
  assign fl_addr  = {bank_q, off_sel ? idx : {OFF_W{1'b0}}};

  // R4
  poll_read_follows_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_POLL_CMD) |=> (fl_re && fl_addr == {bank_q, {OFF_W{1'b0}}}));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(fl_we && fl_re));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!busy && $past(busy)));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start) |=> ($stable(bank_q) && $stable(op_q)));

  // R5
  timeout_to_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(timeout) |-> (st_q == S_CLEAR));
endmodule

// File: tb/flash_bank_prog_tb.sv
module flash_bank_prog_tb;
  localparam int BB    = 16;
  localparam int NB    = 4;
  localparam int LIM   = 6;
  localparam int OW    = $clog2(BB);
  localparam int BW    = $clog2(NB);
  localparam int AW    = OW + BW;
  localparam int TOT   = BB * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, op_prog;
  logic [BW-1:0] bank;
  logic          busy, done, timeout, verify_fail;
  logic [2:0]    err_code;
  logic [OW-1:0] buf_addr;
  logic [7:0]    buf_rdata;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we, fl_re;
  logic [7:0]    fl_rdata;

  int n_checks = 0;
  int n_err    = 0;
  int seed     = 5;
  int delay    = 0;
  int errinj   = 0;
  int corrupt  = -1;
  int model_err = 0;
  int poke     = 0;
  int cur_bank = 0;
  bit cur_prog = 0;

  always #2 clk = ~clk;

  flash_bank_prog #(.BANK_BYTES(BB), .NUM_BANKS(NB), .POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank(bank),
    .busy(busy), .done(done), .timeout(timeout), .verify_fail(verify_fail),
    .err_code(err_code), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata));

  function automatic logic [7:0] buf_byte(input int i);
    return 8'((i * 37 + seed) & 255);
  endfunction

  assign buf_rdata = buf_byte(int'(buf_addr));

  // behavioural flash
  logic [7:0] mem [0:TOT-1];
  int m_cnt  = 0;
  int m_pend = 0;
  bit m_stat = 0;

  initial begin
    for (int i = 0; i < TOT; i++) mem[i] = 8'hFF;
    fl_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (m_cnt > 0) m_cnt <= m_cnt - 1;
    if (fl_we) begin
      if (m_pend == 1) begin
        mem[fl_addr] <= (int'(fl_addr) == corrupt) ? (fl_wdata ^ 8'h01) : fl_wdata;
        m_cnt <= delay; m_pend <= 0; m_stat <= 1'b1;
      end else begin
        case (fl_wdata)
          8'h40: m_pend <= 1;
          8'h20: m_pend <= 2;
          8'hD0: begin
            if (m_pend == 2) begin
              for (int i = 0; i < BB; i++) begin
                int a;
                a = (int'(fl_addr) & ~(BB - 1)) + i;
                mem[a] <= (a == corrupt) ? 8'hFE : 8'hFF;
              end
              m_cnt <= delay; m_stat <= 1'b1;
            end else model_err <= model_err + 1;
            m_pend <= 0;
          end
          8'h70: m_stat <= 1'b1;
          8'hFF: m_stat <= 1'b0;
          default: ;
        endcase
      end
    end
    if (fl_re)
      fl_rdata <= m_stat ? {(m_cnt == 0), 1'b0, (m_cnt == 0) ? 3'(errinj) : 3'b000, 3'b000}
                         : mem[fl_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one reference cycle: wait for the sampling point and compare the bus
  task automatic cyc(input bit ewe, input bit ere, input int ea, input int ed, input string req);
    int a, e;
    string r;
    @(negedge clk);
    r = (poke == 2) ? "R10" : req;
    a = (int'(busy) << 26) | (int'(fl_we) << 25) | (int'(fl_re) << 24)
      | ((ewe || ere) ? (int'(fl_addr) << 8) : 0) | (ewe ? int'(fl_wdata) : 0);
    e = (1 << 26) | (int'(ewe) << 25) | (int'(ere) << 24)
      | ((ewe || ere) ? (ea << 8) : 0) | (ewe ? (ed & 255) : 0);
    check(a == e, r, a, e);
    if (poke == 1) begin
      start = 1'b1; op_prog = ~cur_prog; bank = BW'(cur_bank + 1); poke = 2;
    end else if (poke == 2) begin
      start = 1'b0; op_prog = cur_prog; bank = BW'(cur_bank); poke = 0;
    end
  endtask

  task automatic poll(input int base, output bit to, inout int err);
    int att;
    att = 0;
    to  = 0;
    forever begin
      cyc(1, 0, base, 'h70, "R4");
      att++;
      cyc(0, 1, base, 0, "R4");
      cyc(0, 0, 0, 0, "R4");
      if (fl_rdata[7]) begin
        err = err | int'(fl_rdata[5:3]);
        return;
      end
      if (att == LIM) begin
        to = 1;
        return;
      end
    end
  endtask

  task automatic run_op(input bit prog, input int bk, input int dly, input int einj,
                        input int bad, input bit exp_to, input bit exp_vf, input int exp_err);
    int  base, err;
    bit  to, vf;
    base = bk * BB;
    err = 0; vf = 0; to = 0;
    delay = dly; errinj = einj; corrupt = bad;
    cur_bank = bk; cur_prog = prog;
    @(negedge clk);
    start = 1'b1; op_prog = prog; bank = BW'(bk); poke = 1;
    if (!prog) begin
      cyc(1, 0, base, 'h20, "R2 R11");
      cyc(1, 0, base, 'hD0, "R2");
      poll(base, to, err);
    end else begin
      for (int i = 0; i < BB; i++) begin
        cyc(1, 0, base + i, 'h40, "R3 R11");
        cyc(0, 0, 0, 0, "R3");
        cyc(1, 0, base + i, int'(buf_byte(i)), "R3");
        poll(base, to, err);
        if (to) break;
      end
    end
    cyc(1, 0, base, 'h50, "R6");
    cyc(1, 0, base, 'hFF, "R6");
    for (int i = 0; i < BB; i++) begin
      cyc(0, 1, base + i, 0, "R7 R11");
      cyc(0, 0, 0, 0, "R7");
      if (fl_rdata != (prog ? buf_byte(i) : 8'hFF)) vf = 1;
    end
    @(negedge clk);
    check(done && !busy, "R9 done pulse", {busy, done}, 1);
    check(timeout == exp_to && to == exp_to, "R5 timeout flag", timeout, exp_to);
    check(verify_fail == exp_vf && vf == exp_vf, "R7 verify flag", verify_fail, exp_vf);
    check(int'(err_code) == exp_err && err == exp_err, "R8 error code", err_code, exp_err);
    @(negedge clk);
    check(!done && !busy && timeout == exp_to && verify_fail == exp_vf,
          "R9 flags held", {done, timeout, verify_fail}, {1'b0, exp_to, exp_vf});
  endtask

  task automatic finish_sim();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_prog = 1'b0; bank = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !fl_we && !fl_re, "R1 idle outputs", {busy, done, fl_we, fl_re}, 0);
    check(!timeout && !verify_fail && err_code == 3'b000, "R1 flags",
          {timeout, verify_fail, err_code}, 0);

    seed = 5;
    run_op(0, 1, 2, 0, -1, 0, 0, 0);          // erase, clean
    run_op(1, 2, 0, 0, -1, 0, 0, 0);          // program, ready at once
    run_op(1, 0, 3, 5, -1, 0, 0, 5);          // program, R8 error bits
    run_op(0, 3, 0, 0, 3 * BB + 7, 0, 1, 0);  // erase, one bad byte
    seed = 9;
    run_op(1, 3, 1, 0, 3 * BB + 4, 0, 1, 0);  // program, one bad byte
    run_op(0, 2, 1000, 0, -1, 1, 0, 0);       // erase never ready
    seed = 5;
    run_op(1, 1, 1000, 0, -1, 1, 1, 0);       // program aborted after first byte
    run_op(0, 0, 5, 2, -1, 0, 0, 2);          // erase with error bits

    check(model_err == 0, "R2 confirm order", model_err, 0);
    finish_sim();
  end
endmodule